// File: doc/BRIEF.md
# Toggle-Saturating Power Stress Generator

This block exists to load an FPGA power-measurement setup with as much flip-flop switching as a simple structure can give. A one-bit source register flips its own value on every enabled clock edge and feeds the top of a long register chain. Each edge moves the chain one stage toward stage 0. Once the chain has filled, neighbouring stages always hold opposite values, so every stage changes state on every enabled edge.

The chain is reduced to a single bit in two registered steps. Equal-width groups are XORed into partial registers, and those partials are XORed into one final register. That final bit drives an LED pin, which keeps synthesis from pruning the chain. Every stage has a reset, which stops the tools from packing the chain into shift-register lookup tables. Holding the enable low freezes every register and gives a low-activity baseline to compare against. An optional tap brings stage 0 out to a pin.

Top module: `pwr_toggle_stress`

## Requirements
- R1: While `rst_i` is high at a rising edge, the source bit, every chain stage, every partial-XOR register and `led_o` are cleared to 0.
- R2: On every rising edge with `en_i` high and `rst_i` low, the source bit takes the inverse of its previous value, so that it is 0, 1, 0, 1, ... on consecutive enabled edges after reset.
- R3: On every enabled edge, stage i of the chain takes the old value of stage i+1. Stage LEN-1 takes the old source bit. After n enabled edges from reset, stage LEN-1-j holds (n-j-1) mod 2 when n-j is at least 1, and 0 otherwise.
- R4: After LEN enabled edges from reset, every chain stage takes the inverse of its previous value on every further enabled edge.
- R5: After n enabled edges, `led_o` equals the XOR of all chain stages as they stood after n-2 enabled edges (0 for n below 2). This gives exactly two register stages of latency.
- R6: At a rising edge with `en_i` low and `rst_i` low, no register changes, so `led_o` and `tap_o` hold their values.
- R7: With parameter TAP_ON = 1, `tap_o` shows chain stage 0. With TAP_ON = 0, `tap_o` is constant 0.
- R8: LEN must be a non-zero multiple of GRP, and GRP must be at least 1. Any other setting stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enable; low freezes every register |
| led_o | output | 1 | Registered XOR fold of the whole chain |
| tap_o | output | 1 | Chain stage 0 when TAP_ON = 1, otherwise 0 |

## Verification
The embedded assertions check the following on every cycle: the reset clearing, the top stage following the source bit, the freeze while disabled, the full-chain inversion once the chain has filled, and the two-stage latency of the fold. The bench's scenarios are the only place the exact fill sequence and the LED parity values are compared with values derived arithmetically from the count of enabled edges. The same holds for an enable pattern that stops and resumes mid-fill, a reset in mid-run, and the tap disabled by its parameter.

// File: rtl/pwrstress_pkg.sv
package pwrstress_pkg;

   // number of XOR groups the chain is split into
   function automatic int unsigned fold_groups(input int unsigned len, input int unsigned grp);
      return (grp == 0) ? 1 : len / grp;
   endfunction

   // width of a counter that reaches len
   function automatic int unsigned cnt_width(input int unsigned len);
      return (len < 2) ? 1 : $clog2(len + 1);
   endfunction

endpackage

// File: rtl/pst_toggle_src.sv
module pst_toggle_src (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   output logic bit_o
);

   logic bit_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)     bit_q <= 1'b0;
      else if (en_i) bit_q <= ~bit_q;
   end

   assign bit_o = bit_q;

   AST_SRC_FLIPS: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !rst_i) |=> (bit_q != $past(bit_q)) || $past(rst_i)) else $error("source stuck"); // R2

endmodule

// File: rtl/pst_shift_chain.sv
module pst_shift_chain #(
   parameter int unsigned LEN = 1024
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           en_i,
   input  logic           head_i,
   output logic [LEN-1:0] stage_o
);

   logic [LEN-1:0] stage_q;

   // one reset flop per stage, so the chain cannot be packed into LUT shifters
   for (genvar i = 0; i < LEN; i++) begin : g_stage
      logic nxt;
      if (i == LEN - 1) begin : g_top
         assign nxt = head_i;
      end else begin : g_mid
         assign nxt = stage_q[i+1];
      end
      always_ff @(posedge clk_i) begin
         if (rst_i)     stage_q[i] <= 1'b0;
         else if (en_i) stage_q[i] <= nxt;
      end
   end

   assign stage_o = stage_q;

endmodule

// File: rtl/pst_xor_fold.sv
module pst_xor_fold #(
   parameter int unsigned W   = 1024,
   parameter int unsigned GRP = 32
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         en_i,
   input  logic [W-1:0] din_i,
   output logic         bit_o
);

   localparam int unsigned NG = pwrstress_pkg::fold_groups(W, GRP);

   logic [NG-1:0] part_q;
   logic          fin_q;

   for (genvar g = 0; g < NG; g++) begin : g_part
      always_ff @(posedge clk_i) begin
         if (rst_i)     part_q[g] <= 1'b0;
         else if (en_i) part_q[g] <= ^din_i[g*GRP +: GRP];
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)     fin_q <= 1'b0;
      else if (en_i) fin_q <= ^part_q;
   end

   assign bit_o = fin_q;

   AST_FOLD_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $past(en_i) && !$past(rst_i, 2) && $past(en_i, 2))
         |-> (fin_q == ^$past(din_i, 2))) else $error("fold latency"); // R5

endmodule

// File: rtl/pwr_toggle_stress.sv
module pwr_toggle_stress #(
   parameter int unsigned LEN    = 1024,
   parameter int unsigned GRP    = 32,
   parameter bit          TAP_ON = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   output logic led_o,
   output logic tap_o
);

   localparam int unsigned CW = pwrstress_pkg::cnt_width(LEN);

   if (GRP < 1 || LEN < 1 || (LEN % GRP) != 0) begin : g_bad_cfg
      $error("LEN must be a non-zero multiple of GRP"); // R8
   end

   logic           src;
   logic [LEN-1:0] chain;

   pst_toggle_src i_src (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .en_i  (en_i),
      .bit_o (src)
   );

   pst_shift_chain #(.LEN(LEN)) i_chain (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (en_i),
      .head_i  (src),
      .stage_o (chain)
   );

   pst_xor_fold #(.W(LEN), .GRP(GRP)) i_fold (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .en_i  (en_i),
      .din_i (chain),
      .bit_o (led_o)
   );

   if (TAP_ON) begin : g_tap
      assign tap_o = chain[0];
   end else begin : g_notap
      assign tap_o = 1'b0;
   end

   // enabled edges since reset, saturating at LEN (assertion support only)
   logic [CW-1:0] fill_q;
   always_ff @(posedge clk_i) begin
      if (rst_i)                                fill_q <= '0;
      else if (en_i && fill_q != CW'(LEN))      fill_q <= fill_q + 1'b1;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk_i)
      rst_i |=> (src == 1'b0 && chain == '0 && led_o == 1'b0)) else $error("reset"); // R1
   AST_HEAD_FROM_SRC: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $past(en_i)) |-> (chain[LEN-1] == $past(src))) else $error("head"); // R3
   AST_ALL_TOGGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (fill_q == CW'(LEN) && en_i) |=> (chain == ~$past(chain))) else $error("toggle"); // R4
   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> ($stable(chain) && $stable(src) && $stable(led_o))) else $error("hold"); // R6

endmodule

// File: tb/test_pwr_toggle_stress.sv
module test_pwr_toggle_stress;

   localparam int LEN = 16;
   localparam int GRP = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic led, tap, led_nt, tap_nt;

   int checks = 0;
   int errors = 0;
   int n = 0;          // enabled edges since reset
   bit prev_tap;

   always #5 clk = ~clk;

   pwr_toggle_stress #(.LEN(LEN), .GRP(GRP), .TAP_ON(1'b1)) i_pwr_toggle_stress (
      .clk_i(clk), .rst_i(rst), .en_i(en), .led_o(led), .tap_o(tap));

   pwr_toggle_stress #(.LEN(LEN), .GRP(GRP), .TAP_ON(1'b0)) i_pwr_toggle_stress_notap (
      .clk_i(clk), .rst_i(rst), .en_i(en), .led_o(led_nt), .tap_o(tap_nt));

   function automatic bit chain_bit(int k, int i);
      int m = k - (LEN - 1 - i);
      return (m >= 1) ? bit'((m - 1) & 1) : 1'b0;
   endfunction

   function automatic bit chain_par(int k);
      bit p = 1'b0;
      for (int i = 0; i < LEN; i++) p ^= chain_bit(k, i);
      return p;
   endfunction

   function automatic bit exp_led(int k);
      return (k >= 2) ? chain_par(k - 2) : 1'b0;
   endfunction

   task automatic chk(input bit got, input bit exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s n=%0d actual=%b expected=%b", req, n, got, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      n = 0;
      chk(led, 1'b0, "R1 led");
      chk(tap, 1'b0, "R1 tap");
      chk(led_nt, 1'b0, "R1 led notap");
      rst = 1'b0;
   endtask

   // one clock with the given enable, then check both outputs
   task automatic cyc(input bit e);
      bit old_led = led;
      bit old_tap = tap;
      en = e;
      @(posedge clk);
      #2;
      if (e) n++;
      if (!e) begin
         chk(led, old_led, "R6 led held");
         chk(tap, old_tap, "R6 tap held");
      end
      chk(led, exp_led(n), "R5 led fold");
      chk(tap, chain_bit(n, 0), "R3 tap stage0");
      chk(led_nt, exp_led(n), "R5 led notap");
      chk(tap_nt, 1'b0, "R7 tap off");
      if (e && n > LEN) chk(tap, ~old_tap, "R4 toggle");
      // R2: after fill the tap replays the source sequence 0,1,0,...
      if (n >= LEN + 1) chk(tap, bit'((n - LEN) & 1), "R2 source phase");
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2;
      do_reset();
      // continuous fill and run
      for (int k = 0; k < 3 * LEN; k++) cyc(1'b1);
      // restart, stall mid-fill with alternating enable
      do_reset();
      for (int k = 0; k < 4 * LEN; k++) cyc(bit'(k % 2));
      // bursts: three on, two off
      for (int k = 0; k < 40; k++) cyc(bit'((k % 5) < 3));
      // long idle then resume
      for (int k = 0; k < 10; k++) cyc(1'b0);
      for (int k = 0; k < LEN; k++) cyc(1'b1);
      // reset mid-run, then enable for just one and two edges
      do_reset();
      cyc(1'b1);
      cyc(1'b0);
      cyc(1'b1);
      for (int k = 0; k < 2 * LEN; k++) cyc(1'b1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule